// File: doc/BRIEF.md
# Last Branch Record Stack

This block keeps a short history of taken control-flow transfers. A branch monitor hands it one committed branch per accepted beat: the branch class, whether the target runs at user privilege, and the source and target addresses. Each recorded branch fills one slot of a circular store of address pairs. A top pointer always names the newest slot.

A select register filters what is kept. A set bit suppresses a class or a target privilege. One select bit switches the store into call-chain mode. In that mode calls push a slot and returns pop the newest one, so a function that has already returned leaves nothing behind. A control register turns recording on and can freeze recording when a performance interrupt arrives. A small register port gives software the controls, the pointer, the valid mask and every stored pair.

The depth must be a power of two no larger than 64, and the address width must be at least the depth.

Top module: `lbr_stack`

## Requirements
- R1: After reset the top pointer is 0, all valid bits are 0, every stored address reads 0, and the control and select registers read 0. While the control enable bit (bit 0) is 0, branches change neither the pointer nor the valid mask.
- R2: In normal mode (select bit 9 = 0), a branch that is kept advances the pointer by one modulo DEPTH. It writes its source and target into the slot the new pointer names and sets that slot's valid bit. After DEPTH further captures, the oldest slot is overwritten.
- R3: Branch class codes on `br_kind` are: 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch. Select bit 2+code suppresses that class.
- R4: Select bit 0 suppresses branches whose target is kernel (`br_to_user` = 0). Select bit 1 suppresses branches whose target is user (`br_to_user` = 1).
- R5: In call-chain mode (select bit 9 = 1), an unsuppressed call (code 1 or 2) pushes exactly as in R2. An unsuppressed return (code 3) clears the valid bit of the slot under the pointer and moves the pointer back by one modulo DEPTH. All other classes are never kept.
- R6: A return in call-chain mode whose pointer slot is not valid changes neither the pointer nor the valid mask.
- R7: Control bit 1 enables freezing. When it is set, a one-cycle `pmi` pulse sets the frozen flag (control bit 2) in the next cycle. While the flag is set, no branch is kept. A register write to the control register loads the flag from write-data bit 2, unless a freezing pulse arrives in the same cycle; in that case the flag is set.
- R8: Register map on `reg_addr`: 0x00 control, 0x01 select, 0x02 pointer, 0x03 valid mask, 0x40+i source of slot i, 0x80+i target of slot i. Other addresses read 0. Only control and select are writable. `reg_rdata` is registered: it shows the state before the clock edge at which the address was presented, one cycle after that address.
- R9: `br_ready` is always 1. Every cycle with `br_valid` high delivers one branch, and the monitor is never back-pressured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A committed branch is presented |
| br_ready | output | 1 | Always high; the block accepts every beat |
| br_kind | input | 3 | Branch class code (R3) |
| br_to_user | input | 1 | Target runs at user privilege |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| pmi | input | 1 | Performance interrupt pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | AW | Registered read data |

## Verification
The filter is swept exhaustively. Every combination of the seven class bits and the two privilege bits is paired with every class code and both target privileges. This separates class suppression from privilege suppression, and a wrong bit index shows up as a pointer mismatch.

Call-chain mode is tried with three kinds of traffic:
- returns on an empty store, which tells a correct underflow guard from a wrapping pop;
- a push run longer than the depth followed by a full drain, which exercises wrap in both directions;
- a pseudo-random mix of all classes, which shows that jumps are ignored while calls and returns are not.

Freeze, enable and read latency are each probed with a branch placed right after, or in the same cycle as, the control change.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int SEL_W = 10;
  // select bit positions
  localparam int SEL_NO_KERN = 0;
  localparam int SEL_NO_USER = 1;
  localparam int SEL_CLASS0  = 2;
  localparam int SEL_CHAIN   = 9;
  // branch class codes
  localparam logic [2:0] BK_COND  = 3'd0;
  localparam logic [2:0] BK_RCALL = 3'd1;
  localparam logic [2:0] BK_ICALL = 3'd2;
  localparam logic [2:0] BK_RET   = 3'd3;
  localparam logic [2:0] BK_IJMP  = 3'd4;
  localparam logic [2:0] BK_RJMP  = 3'd5;
  localparam logic [2:0] BK_FAR   = 3'd6;
  // register addresses
  localparam logic [7:0] RA_CTRL  = 8'h00;
  localparam logic [7:0] RA_SEL   = 8'h01;
  localparam logic [7:0] RA_TOS   = 8'h02;
  localparam logic [7:0] RA_VALID = 8'h03;
  localparam logic [1:0] RA_FROM_PG = 2'b01;
  localparam logic [1:0] RA_TO_PG   = 2'b10;

  typedef struct packed {
    logic frozen;
    logic freeze_en;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/lbr_classify.sv
module lbr_classify
  import lbr_pkg::*;
(
  input  logic             valid,
  input  logic             rec_en,
  input  logic [2:0]       kind,
  input  logic             to_user,
  input  logic [SEL_W-1:0] sel,
  output logic             push,
  output logic             pop
);
  logic cls_sup, priv_sup, take, is_call, is_ret;

  always_comb begin
    case (kind)
      BK_COND:  cls_sup = sel[SEL_CLASS0 + 0];
      BK_RCALL: cls_sup = sel[SEL_CLASS0 + 1];
      BK_ICALL: cls_sup = sel[SEL_CLASS0 + 2];
      BK_RET:   cls_sup = sel[SEL_CLASS0 + 3];
      BK_IJMP:  cls_sup = sel[SEL_CLASS0 + 4];
      BK_RJMP:  cls_sup = sel[SEL_CLASS0 + 5];
      BK_FAR:   cls_sup = sel[SEL_CLASS0 + 6];
      default:  cls_sup = 1'b1;
    endcase
    priv_sup = to_user ? sel[SEL_NO_USER] : sel[SEL_NO_KERN];
    take     = valid && rec_en && !cls_sup && !priv_sup;
    is_call  = (kind == BK_RCALL) || (kind == BK_ICALL);
    is_ret   = (kind == BK_RET);
    push     = take && (!sel[SEL_CHAIN] || is_call);
    pop      = take && sel[SEL_CHAIN] && is_ret;
  end
endmodule

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import lbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [SEL_W-1:0] wdata,
  input  logic             pmi,
  output ctrl_t            ctrl,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      sel  <= '0;
    end else begin
      if (we && addr == RA_CTRL) begin
        ctrl.enable    <= wdata[0];
        ctrl.freeze_en <= wdata[1];
        ctrl.frozen    <= wdata[2];
      end
      if (we && addr == RA_SEL)
        sel <= wdata;
      if (pmi && ctrl.freeze_en)
        ctrl.frozen <= 1'b1;
    end
  end
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic                      pop,
  input  logic [AW-1:0]             from_in,
  input  logic [AW-1:0]             to_in,
  output logic [PW-1:0]             tos,
  output logic [DEPTH-1:0]          valid,
  output logic [DEPTH-1:0][AW-1:0]  from_q,
  output logic [DEPTH-1:0][AW-1:0]  to_q
);
  logic [PW-1:0] tos_up, tos_dn;
  assign tos_up = tos + PW'(1);
  assign tos_dn = tos - PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos   <= '0;
      valid <= '0;
    end else if (push) begin
      tos           <= tos_up;
      valid[tos_up] <= 1'b1;
    end else if (pop && valid[tos]) begin
      tos        <= tos_dn;
      valid[tos] <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        from_q[g] <= '0;
        to_q[g]   <= '0;
      end else if (push && tos_up == PW'(g)) begin
        from_q[g] <= from_in;
        to_q[g]   <= to_in;
      end
    end
  end
endmodule

// File: rtl/lbr_stack.sv
module lbr_stack
  import lbr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  output logic             br_ready,
  input  logic [2:0]       br_kind,
  input  logic             br_to_user,
  input  logic [AW-1:0]    br_from,
  input  logic [AW-1:0]    br_to,
  input  logic             pmi,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [SEL_W-1:0] reg_wdata,
  output logic [AW-1:0]    reg_rdata
);
  localparam int PW = $clog2(DEPTH);

  ctrl_t                     ctrl_w;
  logic [SEL_W-1:0]          sel_w;
  logic                      push_w, pop_w, rec_en_w;
  logic [PW-1:0]             tos_w;
  logic [DEPTH-1:0]          valid_w;
  logic [DEPTH-1:0][AW-1:0]  from_w, to_w;
  logic [AW-1:0]             rd_next;

  assign br_ready = 1'b1;
  assign rec_en_w = ctrl_w.enable && !ctrl_w.frozen;

  lbr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .pmi(pmi), .ctrl(ctrl_w), .sel(sel_w)
  );

  lbr_classify u_cls (
    .valid(br_valid), .rec_en(rec_en_w), .kind(br_kind),
    .to_user(br_to_user), .sel(sel_w), .push(push_w), .pop(pop_w)
  );

  lbr_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
    .from_in(br_from), .to_in(br_to), .tos(tos_w), .valid(valid_w),
    .from_q(from_w), .to_q(to_w)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr == RA_CTRL)       rd_next = AW'(ctrl_w);
    else if (reg_addr == RA_SEL)   rd_next = AW'(sel_w);
    else if (reg_addr == RA_TOS)   rd_next = AW'(tos_w);
    else if (reg_addr == RA_VALID) rd_next = AW'(valid_w);
    else if (int'(reg_addr[5:0]) < DEPTH) begin
      if (reg_addr[7:6] == RA_FROM_PG)    rd_next = from_w[reg_addr[PW-1:0]];
      else if (reg_addr[7:6] == RA_TO_PG) rd_next = to_w[reg_addr[PW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end
endmodule

// File: rtl/lbr_stack_chk.sv
module lbr_stack_chk
  import lbr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             pop,
  input logic             enable,
  input logic             frozen,
  input logic [PW-1:0]    tos,
  input logic [DEPTH-1:0] valid,
  input logic [7:0]       reg_addr,
  input logic [AW-1:0]    reg_rdata
);
  p_push_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (tos == PW'($past(tos) + 1'b1)) && valid[tos]);

  p_pop_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && valid[tos]) |=> (tos == PW'($past(tos) - 1'b1)));

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !valid[tos]) |=> $stable(tos) && $stable(valid));

  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(tos) && $stable(valid));

  p_disabled_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(tos) && $stable(valid));

  p_tos_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_TOS) |=> (reg_rdata == AW'($past(tos))));
endmodule

bind lbr_stack lbr_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
  .enable(ctrl_w.enable), .frozen(ctrl_w.frozen), .tos(tos_w),
  .valid(valid_w), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/lbr_stack_tb_top.sv
`timescale 1ns/1ps
module lbr_stack_tb_top;
  localparam int D = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        br_valid = 0;
  logic        br_ready;
  logic [2:0]  br_kind = 0;
  logic        br_to_user = 0;
  logic [31:0] br_from = 0, br_to = 0;
  logic        pmi = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [9:0]  reg_wdata = 0;
  logic [31:0] reg_rdata;

  int n_tests = 0, n_fail = 0;

  // bench model
  logic [31:0] m_from [D];
  logic [31:0] m_to   [D];
  logic [D-1:0] m_valid;
  int          m_tos;
  logic [9:0]  m_sel;
  logic        m_en, m_fen, m_frozen;

  always #4 clk = ~clk;

  lbr_stack dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
    .br_kind(br_kind), .br_to_user(br_to_user), .br_from(br_from),
    .br_to(br_to), .pmi(pmi), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < D; i++) begin m_from[i] = 0; m_to[i] = 0; end
    m_valid = 0; m_tos = 0; m_sel = 0; m_en = 0; m_fen = 0; m_frozen = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  task automatic wr(input logic [7:0] a, input logic [9:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (a == 8'h00) begin m_en = d[0]; m_fen = d[1]; m_frozen = d[2]; end
    if (a == 8'h01) m_sel = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  // expected effect of one branch, from R2..R7
  task automatic model_branch(input logic [2:0] k, input logic u,
                              input logic [31:0] f, input logic [31:0] t);
    logic keep;
    keep = m_en && !m_frozen && !m_sel[2 + k] && !(u ? m_sel[1] : m_sel[0]);
    if (keep) begin
      if (!m_sel[9] || k == 3'd1 || k == 3'd2) begin
        m_tos = (m_tos + 1) % D;
        m_from[m_tos] = f; m_to[m_tos] = t; m_valid[m_tos] = 1'b1;
      end else if (k == 3'd3 && m_valid[m_tos]) begin
        m_valid[m_tos] = 1'b0;
        m_tos = (m_tos + D - 1) % D;
      end
    end
  endtask

  task automatic br(input logic [2:0] k, input logic u,
                    input logic [31:0] f, input logic [31:0] t);
    @(negedge clk);
    br_valid = 1; br_kind = k; br_to_user = u; br_from = f; br_to = t;
    @(negedge clk); br_valid = 0;
    model_branch(k, u, f, t);
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    rd(8'h02, d); chk({req, " pointer"}, d, 32'(m_tos));
    rd(8'h03, d); chk({req, " valid mask"}, d, 32'(m_valid));
  endtask

  task automatic check_entries(input string req);
    logic [31:0] d;
    for (int i = 0; i < D; i++) begin
      rd(8'h40 + 8'(i), d); chk({req, " source"}, d, m_from[i]);
      rd(8'h80 + 8'(i), d); chk({req, " target"}, d, m_to[i]);
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] lf;
    int seq;
    model_clear();
    do_reset();

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl after reset", d, 0);
    rd(8'h01, d); chk("R1 select after reset", d, 0);
    check_state("R1 reset");
    rd(8'h40, d); chk("R1 slot0 source", d, 0);
    rd(8'hC0, d); chk("R8 unmapped address", d, 0);
    chk("R9 ready high", 32'(br_ready), 1);

    // R1 disabled: nothing kept
    br(3'd0, 1'b1, 32'h100, 32'h200);
    br(3'd1, 1'b0, 32'h101, 32'h201);
    check_state("R1 disabled");

    // R3/R4 exhaustive filter sweep, normal mode
    wr(8'h00, 10'h001);
    seq = 0;
    for (int s = 0; s < 128; s++) begin
      for (int p = 0; p < 4; p++) begin
        wr(8'h01, {1'b0, 7'(s), 2'(p)});
        for (int k = 0; k < 7; k++) begin
          for (int u = 0; u < 2; u++) begin
            seq++;
            br(3'(k), 1'(u), 32'h1000_0000 + 32'(seq), 32'h2000_0000 + 32'(seq));
          end
        end
        rd(8'h02, d); chk("R3 R4 pointer after filter sweep step", d, 32'(m_tos));
      end
    end
    check_state("R3 R4 sweep end");
    chk("R9 ready during traffic", 32'(br_ready), 1);

    // R2 wrap: more captures than depth
    wr(8'h01, 10'h000);
    for (int i = 0; i < D + 5; i++) br(3'(i % 7), 1'(i % 2), 32'hA000 + 32'(i), 32'hB000 + 32'(i));
    check_state("R2 wrap");
    check_entries("R2 wrap");

    // R8 registered read: value seen after edge is pre-edge state
    @(negedge clk);
    reg_addr = 8'h02; br_valid = 1; br_kind = 3'd0; br_to_user = 1;
    br_from = 32'hC0; br_to = 32'hC1;
    @(negedge clk); br_valid = 0;
    chk("R8 read shows pre-edge pointer", reg_rdata, 32'(m_tos));
    model_branch(3'd0, 1'b1, 32'hC0, 32'hC1);
    @(negedge clk);
    chk("R8 read shows updated pointer", reg_rdata, 32'(m_tos));

    // R5 R6 call-chain mode
    do_reset();
    wr(8'h00, 10'h001);
    wr(8'h01, 10'h200);
    for (int i = 0; i < 3; i++) br(3'd3, 1'b0, 32'h0, 32'h0);
    check_state("R6 pop on empty");
    for (int i = 0; i < D + 4; i++) br(3'(1 + i % 2), 1'b1, 32'hD000 + 32'(i), 32'hE000 + 32'(i));
    check_state("R5 push run");
    check_entries("R5 push run");
    for (int i = 0; i < D + 1; i++) begin
      br(3'd3, 1'b1, 32'h0, 32'h0);
      check_state("R5 R6 drain");
    end
    br(3'd0, 1'b0, 32'h1, 32'h2); br(3'd4, 1'b0, 32'h1, 32'h2);
    br(3'd5, 1'b1, 32'h1, 32'h2); br(3'd6, 1'b1, 32'h1, 32'h2);
    check_state("R5 jumps ignored");
    lf = 16'hACE1;
    for (int i = 0; i < 150; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      br(3'(lf[2:0] % 3'd7), lf[3], 32'hF000 + 32'(i), 32'hF800 + 32'(i));
      if (lf[4]) wr(8'h01, {1'b1, 7'b0, 1'b0, lf[5] & lf[6]});
      check_state("R5 mixed traffic");
    end
    check_entries("R5 mixed traffic");

    // R7 freeze on interrupt
    do_reset();
    wr(8'h00, 10'h003);
    br(3'd0, 1'b0, 32'h11, 32'h12);
    @(negedge clk); pmi = 1;
    @(negedge clk); pmi = 0;
    if (m_fen) m_frozen = 1;
    rd(8'h00, d); chk("R7 frozen flag set", d, 32'h7);
    br(3'd0, 1'b0, 32'h21, 32'h22);
    br(3'd1, 1'b1, 32'h23, 32'h24);
    check_state("R7 frozen no capture");
    wr(8'h00, 10'h003);
    br(3'd5, 1'b0, 32'h31, 32'h32);
    check_state("R7 after unfreeze");
    check_entries("R7 after unfreeze");
    wr(8'h00, 10'h001);
    @(negedge clk); pmi = 1;
    @(negedge clk); pmi = 0;
    rd(8'h00, d); chk("R7 pulse without freeze enable", d, 32'h1);
    br(3'd6, 1'b1, 32'h41, 32'h42);
    check_state("R7 recording continues");
    // write clearing frozen in the same cycle as a freezing pulse: pulse wins
    wr(8'h00, 10'h007);
    @(negedge clk); pmi = 1; reg_we = 1; reg_addr = 8'h00; reg_wdata = 10'h003;
    @(negedge clk); pmi = 0; reg_we = 0;
    m_frozen = 1;
    rd(8'h00, d); chk("R7 pulse beats clearing write", d, 32'h7);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule